// File: doc/BRIEF.md
# Stack Bytecode Execution Core

This block is a multicycle processor core that runs a compact integer stack-machine bytecode. It fetches one opcode or operand byte per cycle from a byte-wide instruction port, addressed by its program counter. It keeps the operand stack and the local variables in a word-wide data memory that is reached through a single request port. The core holds the value on top of the stack in a register of its own, so most operations need only one memory read.

Words sit in data memory with their four bytes in reverse order compared with the core's registers. The core swaps the bytes on every read and on every write. The data memory answers reads after a variable latency, and the core waits for the read-valid signal before it uses the returned word. A one-cycle character strobe serves as the only program output. A halted flag and an error flag report the end of a run.

Top module: `stack_core`

## Requirements
- R1: After reset the frame base register holds STACK_BASE and the stack pointer holds STACK_BASE-1, so the first push writes word address STACK_BASE. While reset is held, imem_addr_o is 0 and halted_o, error_o, dmem_req_o and char_valid_o are all 0.
- R2: dmem_addr_o is a byte address equal to the word address times four, so bits [1:0] are always 0. In memory, bits [7:0] hold register bits [31:24], bits [15:8] hold [23:16], and so on, for both reads and writes.
- R3: The push-byte operation (0x10, one operand) sign-extends its operand byte and pushes it, and the pushed value becomes the top of stack. Local-variable indexes are zero-extended: index 0x90 addresses frame base + 144.
- R4: Add (0x60), subtract (0x64), and (0x7E) and or (0xB0) pop the top word, combine it with the word below, and leave the result on the stack at the new top. Subtract yields below minus top.
- R5: Pop (0x57) drops the top word, and the word below becomes the top of stack. Duplicate (0x59) pushes a copy of the top of stack.
- R6: Swap (0x5F) exchanges the two top stack words in memory. The top of stack afterwards is the word that was second.
- R7: Load-local (0x15, index) pushes the word at frame base + index. Store-local (0x36, index) writes the top of stack there, pops, and reloads the top of stack from memory.
- R8: Increment-local (0x84, index, amount) adds the sign-extended amount byte to the local variable in memory.
- R9: Jump (0xA7, high byte, low byte) sets PC to the address of the jump opcode plus the signed 16-bit offset {high, low}. Backward offsets work.
- R10: Branch-if-zero (0x99) and branch-if-negative (0x9B) take two offset bytes like the jump. They pop the top of stack and reload the top from memory. The branch is taken with the jump's target rule when the popped value is zero or negative, respectively. Otherwise execution continues after the offset bytes.
- R11: Output (0xFD, byte) raises char_valid_o for exactly one cycle with char_o equal to the unsigned operand byte.
- R12: No-op (0x00) changes nothing. Halt (0xFF) sets halted_o permanently. Once halted, PC, the data port and the character port stay idle.
- R13: An opcode outside the set above sets error_o and halted_o.
- R14: At most one data read is outstanding at a time. After a read request the core issues no further request until dmem_rvalid_i returns, however long that takes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr_o | output | PC_W | Byte address of the instruction stream (PC) |
| imem_data_i | input | 8 | Instruction byte at imem_addr_o, same cycle |
| dmem_req_o | output | 1 | Data memory access request, one cycle per access |
| dmem_we_o | output | 1 | 1 = write, 0 = read |
| dmem_addr_o | output | DADDR_W | Byte address of the word |
| dmem_wdata_o | output | DATA_W | Write data in memory byte order |
| dmem_rdata_i | input | DATA_W | Read data in memory byte order |
| dmem_rvalid_i | input | 1 | Read data valid |
| char_valid_o | output | 1 | Character strobe |
| char_o | output | 8 | Character value |
| halted_o | output | 1 | Core has stopped |
| error_o | output | 1 | Stopped on an undefined opcode |

## Verification
The bench targets sign-extension mistakes: a core that zero-extends push or increment operands, or sign-extends the 0x90 local index, leaves wrong words in memory or reads from a wrapped address. Operand order in subtract and the reversed byte layout are checked through the raw memory image, so a missing or duplicated swap shows up directly. Jump targets are tested forward and backward. A target computed from the operand address instead of the opcode address lands on an operand byte and trips the error flag. The read latency varies between one and three cycles, so a core that consumes MDR early, or issues a second request while a read is pending, is caught.

// File: rtl/sc_pkg.sv
package sc_pkg;

   // opcode encodings
   localparam logic [7:0] OPC_NOP    = 8'h00;
   localparam logic [7:0] OPC_PUSHB  = 8'h10;
   localparam logic [7:0] OPC_LDLOC  = 8'h15;
   localparam logic [7:0] OPC_STLOC  = 8'h36;
   localparam logic [7:0] OPC_DROP   = 8'h57;
   localparam logic [7:0] OPC_DUP    = 8'h59;
   localparam logic [7:0] OPC_SWAP   = 8'h5F;
   localparam logic [7:0] OPC_ADD    = 8'h60;
   localparam logic [7:0] OPC_SUB    = 8'h64;
   localparam logic [7:0] OPC_AND    = 8'h7E;
   localparam logic [7:0] OPC_INCLOC = 8'h84;
   localparam logic [7:0] OPC_BRZ    = 8'h99;
   localparam logic [7:0] OPC_BRNEG  = 8'h9B;
   localparam logic [7:0] OPC_JMP    = 8'hA7;
   localparam logic [7:0] OPC_OR     = 8'hB0;
   localparam logic [7:0] OPC_PUTC   = 8'hFD;
   localparam logic [7:0] OPC_HALT   = 8'hFF;

   typedef enum logic [2:0] {
      ST_FETCH, ST_ARG, ST_STEP_A, ST_STEP_B, ST_STEP_C, ST_RDWAIT, ST_STOP
   } state_t;

   typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR} alu_op_t;

   typedef struct packed {
      logic       known;
      logic [1:0] nargs;
      alu_op_t    alu;
   } dec_t;

endpackage

// File: rtl/sc_byteswap.sv
module sc_byteswap #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   localparam int NBYTES = DATA_W / 8;

   for (genvar k = 0; k < NBYTES; k++) begin : g_lane
      assign dout[8*k +: 8] = din[8*(NBYTES-1-k) +: 8];
   end
endmodule

// File: rtl/sc_decode.sv
module sc_decode
   import sc_pkg::*;
(
   input  logic [7:0] op_i,
   output dec_t       dec_o
);
   always_comb begin
      dec_o = '{known: 1'b1, nargs: 2'd0, alu: ALU_ADD};
      case (op_i)
         OPC_NOP, OPC_DROP, OPC_DUP, OPC_SWAP, OPC_HALT, OPC_ADD: ;
         OPC_SUB:  dec_o.alu = ALU_SUB;
         OPC_AND:  dec_o.alu = ALU_AND;
         OPC_OR:   dec_o.alu = ALU_OR;
         OPC_PUSHB, OPC_LDLOC, OPC_STLOC, OPC_PUTC: dec_o.nargs = 2'd1;
         OPC_INCLOC, OPC_JMP, OPC_BRZ, OPC_BRNEG:   dec_o.nargs = 2'd2;
         default:  dec_o.known = 1'b0;
      endcase
   end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
   import sc_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] below_i,
   input  logic [DATA_W-1:0] top_i,
   input  alu_op_t           sel_i,
   output logic [DATA_W-1:0] res_o
);
   always_comb begin
      case (sel_i)
         ALU_ADD: res_o = below_i + top_i;
         ALU_SUB: res_o = below_i - top_i;
         ALU_AND: res_o = below_i & top_i;
         default: res_o = below_i | top_i;
      endcase
   end
endmodule

// File: rtl/stack_core.sv
module stack_core
   import sc_pkg::*;
#(
   parameter int PC_W       = 16,
   parameter int DADDR_W    = 16,
   parameter int DATA_W     = 32,
   parameter int STACK_BASE = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   output logic [PC_W-1:0]    imem_addr_o,
   input  logic [7:0]         imem_data_i,
   output logic               dmem_req_o,
   output logic               dmem_we_o,
   output logic [DADDR_W-1:0] dmem_addr_o,
   output logic [DATA_W-1:0]  dmem_wdata_o,
   input  logic [DATA_W-1:0]  dmem_rdata_i,
   input  logic               dmem_rvalid_i,
   output logic               char_valid_o,
   output logic [7:0]         char_o,
   output logic               halted_o,
   output logic               error_o
);
   localparam int MAR_W = DADDR_W - 2;
   localparam logic [MAR_W-1:0] W_ONE  = MAR_W'(1);
   localparam logic [PC_W-1:0]  PC_ONE = PC_W'(1);
   localparam logic [MAR_W-1:0] BASE_W = MAR_W'(STACK_BASE);

   if (DATA_W % 8 != 0 || DATA_W < 16) begin : g_bad_data
      $error("DATA_W must be a multiple of 8 and at least 16");
   end
   if (PC_W < 16) begin : g_bad_pc
      $error("PC_W must hold a 16-bit branch offset");
   end
   if (DADDR_W < 11) begin : g_bad_addr
      $error("DADDR_W must cover an 8-bit local index above the base");
   end
   if (STACK_BASE < 1 || STACK_BASE >= (1 << MAR_W)) begin : g_bad_base
      $error("STACK_BASE out of word address range");
   end

   state_t              state_q;
   logic [PC_W-1:0]     pc_q, op_pc_q;
   logic [MAR_W-1:0]    sp_q, frame_q, mar_q;
   logic [DATA_W-1:0]   tos_q, popv_q, hold_q, mdr_q;
   logic [7:0]          mbr_q, b1_q, op_q;
   logic [1:0]          argtot_q, argn_q;
   alu_op_t             alu_q;
   logic                req_q, we_q, chv_q, err_q;
   logic [7:0]          chr_q;

   dec_t                dec;
   logic [DATA_W-1:0]   rd_swapped, alu_res, sext_mbr;
   logic [MAR_W-1:0]    loc_addr;
   logic signed [15:0]  off16;
   logic [PC_W-1:0]     br_target;
   logic                br_taken;

   sc_decode i_dec (.op_i(imem_data_i), .dec_o(dec));

   sc_byteswap #(.DATA_W(DATA_W)) i_rd_swap (.din(dmem_rdata_i), .dout(rd_swapped));
   sc_byteswap #(.DATA_W(DATA_W)) i_wr_swap (.din(mdr_q), .dout(dmem_wdata_o));

   sc_alu #(.DATA_W(DATA_W)) i_alu (
      .below_i(mdr_q), .top_i(hold_q), .sel_i(alu_q), .res_o(alu_res)
   );

   always_comb begin
      sext_mbr  = DATA_W'(signed'(mbr_q));
      loc_addr  = frame_q + MAR_W'(b1_q);
      off16     = {b1_q, mbr_q};
      br_target = op_pc_q + PC_W'(off16);
      br_taken  = (op_q == OPC_BRZ) ? (popv_q == '0) : popv_q[DATA_W-1];
   end

   assign imem_addr_o  = pc_q;
   assign dmem_req_o   = req_q;
   assign dmem_we_o    = we_q;
   assign dmem_addr_o  = {mar_q, 2'b00};
   assign char_valid_o = chv_q;
   assign char_o       = chr_q;
   assign halted_o     = (state_q == ST_STOP);
   assign error_o      = err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_FETCH;
         pc_q     <= '0;
         op_pc_q  <= '0;
         sp_q     <= BASE_W - W_ONE;
         frame_q  <= BASE_W;
         mar_q    <= '0;
         tos_q    <= '0;
         popv_q   <= '0;
         hold_q   <= '0;
         mdr_q    <= '0;
         mbr_q    <= '0;
         b1_q     <= '0;
         op_q     <= '0;
         argtot_q <= '0;
         argn_q   <= '0;
         alu_q    <= ALU_ADD;
         req_q    <= 1'b0;
         we_q     <= 1'b0;
         chv_q    <= 1'b0;
         chr_q    <= '0;
         err_q    <= 1'b0;
      end else begin
         req_q <= 1'b0;
         we_q  <= 1'b0;
         chv_q <= 1'b0;
         case (state_q)
            ST_FETCH: begin
               op_q     <= imem_data_i;
               mbr_q    <= imem_data_i;
               op_pc_q  <= pc_q;
               pc_q     <= pc_q + PC_ONE;
               argtot_q <= dec.nargs;
               argn_q   <= dec.nargs;
               alu_q    <= dec.alu;
               if (!dec.known) begin
                  err_q   <= 1'b1;
                  state_q <= ST_STOP;
               end else if (imem_data_i == OPC_HALT) begin
                  state_q <= ST_STOP;
               end else if (imem_data_i == OPC_NOP) begin
                  state_q <= ST_FETCH;
               end else if (dec.nargs != 2'd0) begin
                  state_q <= ST_ARG;
               end else begin
                  state_q <= ST_STEP_A;
               end
            end
            ST_ARG: begin
               mbr_q  <= imem_data_i;
               pc_q   <= pc_q + PC_ONE;
               argn_q <= argn_q - 2'd1;
               if (argn_q == argtot_q) b1_q <= imem_data_i;
               if (argn_q == 2'd1) state_q <= ST_STEP_A;
            end
            ST_STEP_A: begin
               state_q <= ST_FETCH;
               case (op_q)
                  OPC_PUSHB: begin
                     sp_q <= sp_q + W_ONE; mar_q <= sp_q + W_ONE;
                     mdr_q <= sext_mbr; tos_q <= sext_mbr;
                     req_q <= 1'b1; we_q <= 1'b1;
                  end
                  OPC_DUP: begin
                     sp_q <= sp_q + W_ONE; mar_q <= sp_q + W_ONE;
                     mdr_q <= tos_q;
                     req_q <= 1'b1; we_q <= 1'b1;
                  end
                  OPC_DROP: begin
                     sp_q <= sp_q - W_ONE; mar_q <= sp_q - W_ONE;
                     req_q <= 1'b1; state_q <= ST_RDWAIT;
                  end
                  OPC_ADD, OPC_SUB, OPC_AND, OPC_OR: begin
                     sp_q <= sp_q - W_ONE; mar_q <= sp_q - W_ONE;
                     hold_q <= tos_q;
                     req_q <= 1'b1; state_q <= ST_RDWAIT;
                  end
                  OPC_SWAP: begin
                     mar_q <= sp_q - W_ONE;
                     req_q <= 1'b1; state_q <= ST_RDWAIT;
                  end
                  OPC_LDLOC, OPC_INCLOC: begin
                     mar_q <= loc_addr;
                     req_q <= 1'b1; state_q <= ST_RDWAIT;
                  end
                  OPC_STLOC: begin
                     mar_q <= loc_addr; mdr_q <= tos_q;
                     req_q <= 1'b1; we_q <= 1'b1; state_q <= ST_STEP_B;
                  end
                  OPC_JMP: pc_q <= br_target;
                  OPC_BRZ, OPC_BRNEG: begin
                     sp_q <= sp_q - W_ONE; mar_q <= sp_q - W_ONE;
                     popv_q <= tos_q;
                     req_q <= 1'b1; state_q <= ST_RDWAIT;
                  end
                  OPC_PUTC: begin
                     chv_q <= 1'b1; chr_q <= mbr_q;
                  end
                  default: ;
               endcase
            end
            ST_RDWAIT: begin
               if (dmem_rvalid_i) begin
                  mdr_q   <= rd_swapped;
                  state_q <= (op_q == OPC_STLOC) ? ST_STEP_C : ST_STEP_B;
               end
            end
            ST_STEP_B: begin
               state_q <= ST_FETCH;
               case (op_q)
                  OPC_DROP: tos_q <= mdr_q;
                  OPC_ADD, OPC_SUB, OPC_AND, OPC_OR: begin
                     tos_q <= alu_res; mdr_q <= alu_res;
                     req_q <= 1'b1; we_q <= 1'b1;
                  end
                  OPC_SWAP: begin
                     hold_q <= mdr_q; mar_q <= sp_q;
                     req_q <= 1'b1; we_q <= 1'b1; state_q <= ST_STEP_C;
                  end
                  OPC_LDLOC: begin
                     sp_q <= sp_q + W_ONE; mar_q <= sp_q + W_ONE;
                     tos_q <= mdr_q;
                     req_q <= 1'b1; we_q <= 1'b1;
                  end
                  OPC_INCLOC: begin
                     mdr_q <= mdr_q + sext_mbr;
                     req_q <= 1'b1; we_q <= 1'b1;
                  end
                  OPC_STLOC: begin
                     sp_q <= sp_q - W_ONE; mar_q <= sp_q - W_ONE;
                     req_q <= 1'b1; state_q <= ST_RDWAIT;
                  end
                  OPC_BRZ, OPC_BRNEG: begin
                     tos_q <= mdr_q;
                     if (br_taken) pc_q <= br_target;
                  end
                  default: ;
               endcase
            end
            ST_STEP_C: begin
               state_q <= ST_FETCH;
               if (op_q == OPC_SWAP) begin
                  mdr_q <= tos_q; mar_q <= sp_q - W_ONE; tos_q <= hold_q;
                  req_q <= 1'b1; we_q <= 1'b1;
               end else begin
                  tos_q <= mdr_q;
               end
            end
            default: state_q <= ST_STOP;
         endcase
      end
   end

   // R12: once stopped, the core never resumes
   a_r12_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      halted_o |=> halted_o);

   // R12: a stopped core leaves the data and character ports idle
   a_r12_quiet_halted: assert property (@(posedge clk) disable iff (!rst_n)
      halted_o |-> (!dmem_req_o && !char_valid_o));

   // R13: the error flag only appears together with the stop
   a_r13_error_stops: assert property (@(posedge clk) disable iff (!rst_n)
      error_o |-> halted_o);

   // R14: a read request is never followed directly by another request
   a_r14_one_read: assert property (@(posedge clk) disable iff (!rst_n)
      (dmem_req_o && !dmem_we_o) |=> !dmem_req_o);

   // R11: the character strobe lasts a single cycle
   a_r11_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      char_valid_o |=> !char_valid_o);

   // R2: lowest memory byte lands in the most significant register byte
   a_r2_read_order: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RDWAIT && dmem_rvalid_i)
         |=> (mdr_q[DATA_W-1 -: 8] == $past(dmem_rdata_i[7:0])));

endmodule

// File: tb/test_stack_core.sv
`timescale 1ns/1ps
module test_stack_core;
   localparam int PC_W = 16, DADDR_W = 16, DATA_W = 32, BASE = 64;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [PC_W-1:0]    imem_addr;
   logic [7:0]         imem_data;
   logic               dreq, dwe, rvalid;
   logic [DADDR_W-1:0] daddr;
   logic [DATA_W-1:0]  wdata, rdata;
   logic               chv, halted, err;
   logic [7:0]         chr;

   always #4 clk = ~clk;

   stack_core #(.PC_W(PC_W), .DADDR_W(DADDR_W), .DATA_W(DATA_W), .STACK_BASE(BASE))
   i_stack_core (
      .clk(clk), .rst_n(rst_n), .imem_addr_o(imem_addr), .imem_data_i(imem_data),
      .dmem_req_o(dreq), .dmem_we_o(dwe), .dmem_addr_o(daddr), .dmem_wdata_o(wdata),
      .dmem_rdata_i(rdata), .dmem_rvalid_i(rvalid), .char_valid_o(chv), .char_o(chr),
      .halted_o(halted), .error_o(err)
   );

   logic [7:0]  imem [256];
   logic [31:0] dmem [512];
   assign imem_data = imem[imem_addr[7:0]];

   int n_chk = 0, n_fail = 0;
   int lat = 1, viol = 0, misal = 0;
   logic       pend = 1'b0;
   int         cnt = 0;
   logic [8:0] paddr = '0;

   // data memory model with programmable read latency
   always @(posedge clk) begin
      rvalid <= 1'b0;
      if (!rst_n) pend <= 1'b0;
      else begin
         if (dreq) begin
            if (daddr[1:0] != 2'b00) misal++;
            if (pend) viol++;
         end
         if (dreq && dwe) dmem[daddr[10:2]] <= wdata;
         if (dreq && !dwe) begin
            pend <= 1'b1; cnt <= lat; paddr <= daddr[10:2];
         end else if (pend) begin
            if (cnt <= 1) begin rvalid <= 1'b1; rdata <= dmem[paddr]; pend <= 1'b0; end
            else cnt <= cnt - 1;
         end
      end
   end

   logic [7:0] chars [8];
   int nchar = 0;
   always @(negedge clk) begin
      if (rst_n && chv) begin
         if (nchar < 8) chars[nchar] = chr;
         nchar++;
      end
   end

   function automatic logic [31:0] rev(input logic [31:0] w);
      return {w[7:0], w[15:8], w[23:16], w[31:24]};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic clear_all();
      for (int k = 0; k < 256; k++) imem[k] = 8'hFF;
      for (int k = 0; k < 512; k++) dmem[k] = '0;
   endtask

   task automatic load(input logic [7:0] p [12]);
      for (int k = 0; k < 12; k++) imem[k] = p[k];
   endtask

   task automatic run(input string tag);
      int waited;
      rst_n = 1'b0;
      nchar = 0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      waited = 0;
      while (!halted && waited < 3000) begin
         @(negedge clk);
         waited++;
      end
      chk({tag, " run reaches halt"}, 32'(halted), 32'd1);
   endtask

   // rows: opcode, first push, second push, expected result
   localparam logic [55:0] VEC [8] = '{
      {8'h60, 8'h05, 8'h03, 32'h0000_0008},
      {8'h60, 8'h7F, 8'h01, 32'h0000_0080},
      {8'h60, 8'hFF, 8'hFE, 32'hFFFF_FFFD},
      {8'h64, 8'h05, 8'h03, 32'h0000_0002},
      {8'h64, 8'h03, 8'h05, 32'hFFFF_FFFE},
      {8'h7E, 8'hF0, 8'h3C, 32'h0000_0030},
      {8'hB0, 8'h81, 8'h06, 32'hFFFF_FF87},
      {8'h7E, 8'h80, 8'hC0, 32'hFFFF_FF80}
   };

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      int bad;
      logic [PC_W-1:0] pc_hold;
      clear_all();
      // R1 reset state
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R1 reset pc", 32'(imem_addr), 32'd0);
      chk("R1 reset halted", 32'(halted), 32'd0);
      chk("R1 reset error", 32'(err), 32'd0);
      chk("R1 reset req", 32'(dreq), 32'd0);
      chk("R1 reset char", 32'(chv), 32'd0);

      // R4 table of binary operations, result then duplicated copy
      for (int i = 0; i < 8; i++) begin
         clear_all();
         load('{8'h10, VEC[i][47:40], 8'h10, VEC[i][39:32], VEC[i][55:48],
                8'h59, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF});
         lat = 1 + (i % 3);
         run("R4");
         chk("R4 binop result", rev(dmem[BASE]), VEC[i][31:0]);
         chk("R4 top of stack copy", rev(dmem[BASE+1]), VEC[i][31:0]);
         chk("R13 no error on valid code", 32'(err), 32'd0);
      end

      // R1 R2 R3 first push, sign extension and byte order
      clear_all();
      load('{8'h10, 8'hFE, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF});
      lat = 1;
      run("R3");
      chk("R2 raw byte order", dmem[BASE], 32'hFEFF_FFFF);
      chk("R3 sign extended push", rev(dmem[BASE]), 32'hFFFF_FFFE);
      chk("R1 nothing below base", dmem[BASE-1], 32'h0);

      // R7 R3 load/store local with unsigned index
      clear_all();
      dmem[BASE+144] = rev(32'd1);
      dmem[BASE-1]   = rev(32'h1234);
      load('{8'h15, 8'h90, 8'h10, 8'h05, 8'h60, 8'h36, 8'h06, 8'h59, 8'hFF, 8'hFF, 8'hFF, 8'hFF});
      lat = 3;
      run("R7");
      chk("R7 store local raw", dmem[BASE+6], 32'h0600_0000);
      chk("R7 reload after store", rev(dmem[BASE]), 32'h0000_1234);
      chk("R3 index 0x90 unsigned", rev(dmem[BASE+144]), 32'd1);

      // R8 increment local, negative and positive amounts
      clear_all();
      dmem[BASE+7] = rev(32'd10);
      dmem[BASE+8] = rev(32'd1);
      load('{8'h84, 8'h07, 8'hFD, 8'h84, 8'h08, 8'h7F, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF});
      lat = 2;
      run("R8");
      chk("R8 increment by -3", rev(dmem[BASE+7]), 32'd7);
      chk("R8 increment by 127", rev(dmem[BASE+8]), 32'd128);

      // R6 swap
      clear_all();
      load('{8'h10, 8'h01, 8'h10, 8'h02, 8'h5F, 8'h59, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF});
      lat = 3;
      run("R6");
      chk("R6 lower word", rev(dmem[BASE]), 32'd2);
      chk("R6 upper word", rev(dmem[BASE+1]), 32'd1);
      chk("R6 new top of stack", rev(dmem[BASE+2]), 32'd1);

      // R5 pop then duplicate
      clear_all();
      load('{8'h10, 8'h03, 8'h10, 8'h04, 8'h57, 8'h59, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF});
      lat = 2;
      run("R5");
      chk("R5 top after pop", rev(dmem[BASE+1]), 32'd3);

      // R9 forward jump
      clear_all();
      load('{8'hA7, 8'h00, 8'h05, 8'hFD, 8'h58, 8'hFD, 8'h41, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF});
      run("R9");
      chk("R9 forward char count", 32'(nchar), 32'd1);
      chk("R9 forward char", 32'(chars[0]), 32'h41);
      chk("R9 forward no error", 32'(err), 32'd0);

      // R9 backward jump
      clear_all();
      load('{8'hA7, 8'h00, 8'h06, 8'hFD, 8'h42, 8'hFF, 8'hA7, 8'hFF, 8'hFD, 8'hFF, 8'hFF, 8'hFF});
      run("R9");
      chk("R9 backward char count", 32'(nchar), 32'd1);
      chk("R9 backward char", 32'(chars[0]), 32'h42);

      // R10 branch-if-zero taken, top reloaded
      clear_all();
      load('{8'h10, 8'h07, 8'h10, 8'h00, 8'h99, 8'h00, 8'h06, 8'hFD, 8'h4E, 8'hFF, 8'h59, 8'hFF});
      lat = 3;
      run("R10");
      chk("R10 zero taken skips output", 32'(nchar), 32'd0);
      chk("R10 top reloaded", rev(dmem[BASE+1]), 32'd7);

      // R10 branch-if-zero not taken
      clear_all();
      load('{8'h10, 8'h07, 8'h10, 8'h01, 8'h99, 8'h00, 8'h06, 8'hFD, 8'h4E, 8'hFF, 8'h59, 8'hFF});
      run("R10");
      chk("R10 nonzero falls through", 32'(nchar), 32'd1);
      chk("R10 fall-through char", 32'(chars[0]), 32'h4E);

      // R10 branch-if-negative taken and not taken
      clear_all();
      load('{8'h10, 8'hFF, 8'h9B, 8'h00, 8'h05, 8'hFD, 8'h4E, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF});
      lat = 1;
      run("R10");
      chk("R10 negative taken", 32'(nchar), 32'd0);
      clear_all();
      load('{8'h10, 8'h00, 8'h9B, 8'h00, 8'h05, 8'hFD, 8'h4E, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF});
      run("R10");
      chk("R10 zero is not negative", 32'(nchar), 32'd1);

      // R11 character output
      clear_all();
      load('{8'hFD, 8'h80, 8'hFD, 8'h61, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF});
      run("R11");
      chk("R11 char count", 32'(nchar), 32'd2);
      chk("R11 first char", 32'(chars[0]), 32'h80);
      chk("R11 second char", 32'(chars[1]), 32'h61);

      // R12 no-op then halt, halted state stays quiet
      clear_all();
      load('{8'h00, 8'h00, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF});
      run("R12");
      chk("R12 pc after halt", 32'(imem_addr), 32'd3);
      chk("R12 no error", 32'(err), 32'd0);
      pc_hold = imem_addr;
      bad = 0;
      repeat (20) begin
         @(negedge clk);
         if (dreq || chv || !halted) bad++;
      end
      chk("R12 quiet while halted", 32'(bad), 32'd0);
      chk("R12 pc frozen", 32'(imem_addr), 32'(pc_hold));

      // R13 undefined opcode
      clear_all();
      load('{8'h10, 8'h05, 8'h01, 8'h10, 8'h06, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF});
      run("R13");
      chk("R13 error flag", 32'(err), 32'd1);
      chk("R13 stops before next push", rev(dmem[BASE+1]), 32'd0);

      // R14 R2 port discipline over the whole run
      chk("R14 no request while read pending", 32'(viol), 32'd0);
      chk("R2 word aligned byte addresses", 32'(misal), 32'd0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule